// File: doc/BRIEF.md
# Memory Type Range Lookup Unit

This block decides which caching attribute applies to a physical address range given as a start address and an exclusive end address. It holds a fine-grained table of 88 one-byte attributes for the lowest megabyte, a set of variable entries (each a base word carrying the attribute in its low byte plus a mask word carrying a valid flag), a default attribute, a two-bit enable field and a high-memory limit register. Software programs all of this through a single write port, one register per cycle.

A lookup is offered on a valid/ready request channel. Requests that are resolved at once (unit not set up, address in the low megabyte, variable entries disabled) return their answer on the cycle after acceptance. Otherwise the unit walks the variable entries one per clock, merging the attributes of every matching entry. It stops early on an uncachable conflict or on a range that only partly overlaps an entry. After the walk it applies the high-memory override and falls back to the default. The answer is held on the response channel until the consumer takes it, and no new request is accepted in the meantime.

Top module: `memtype_resolver`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0.
- R2: Writes use `wr_sel` with these codes: 0 loads fixed slot `wr_idx` with `wr_data[7:0]`; 1 loads the base word of variable entry `wr_idx`; 2 loads its mask word; 3 loads the default attribute from `wr_data[7:0]` and the enable field from `wr_data[11:10]` and marks the unit set up; 4 loads the high-memory limit. A lookup returns 0xFF while no code-3 write has happened since reset, or while the enable field is 00.
- R3: With the fixed table present and a start address below 0x100000, the answer is the fixed slot chosen by the start address alone. Below 0x80000 the slot is start[18:16]. From 0x80000 to 0xBFFFF it is 8 + start[17:14]. From 0xC0000 to 0xFFFFF it is 24 + start[17:12].
- R4: When enable bit 1 is clear, a lookup at or above 0x100000 returns the default attribute, whatever the variable entries hold.
- R5: A variable entry takes part only when bit 11 of its mask word is 1. It covers an address when (addr & mask) equals (base & mask), with bits 11:0 of the mask treated as zero. Its attribute is base bits 7:0.
- R6: If any taking-part entry covers exactly one of the start address and the inclusive end address, the answer is 0xFE.
- R7: Attribute codes are uncachable 0x00, write-combining 0x01, write-through 0x04, write-protect 0x05 and write-back 0x06. Several covering entries merge as follows: uncachable with anything gives uncachable; write-back with write-through gives write-through; equal codes keep that code; any other pair gives uncachable.
- R8: The limit register keeps only bits 35:23 of the written value. When it is nonzero, the start is at least 2^32 and the inclusive end is below the limit, the answer after the walk is write-back. This holds even if variable entries also cover the range.
- R9: When variable entries are enabled and none covers the range, the answer is the default attribute.
- R10: A response stays valid with an unchanged code until `rsp_ready` is 1. While a lookup is in flight or its response is pending, `req_ready` is 0. A walk lasts at most N_VAR cycles.
- R11: The end address is exclusive. A range whose last byte is end-1 counts as covered when end-1 is covered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register kind (see R2) |
| wr_idx | input | 7 | Slot or entry index |
| wr_data | input | 36 | Write data |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_start | input | 36 | First byte of the range |
| req_end | input | 36 | One past the last byte of the range |
| rsp_valid | output | 1 | Answer available |
| rsp_ready | input | 1 | Consumer takes the answer |
| rsp_type | output | 8 | Resolved attribute or error code |

## Verification
The bench builds the unit with its default parameters: eight variable entries, 36-bit addresses and the fixed table present. With 36 bits the address space reaches above 4 GiB, so the high-memory override can be exercised both against an uncachable default and against a covering variable entry. Eight entries let the walk run to its last index, where a match sits in entry 7. The fixed table covers all three granule sizes, and the bench probes the first and last slot of each band.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

    localparam logic [7:0] MT_UC      = 8'h00;
    localparam logic [7:0] MT_WC      = 8'h01;
    localparam logic [7:0] MT_WT      = 8'h04;
    localparam logic [7:0] MT_WP      = 8'h05;
    localparam logic [7:0] MT_WB      = 8'h06;
    localparam logic [7:0] MT_PARTIAL = 8'hFE;
    localparam logic [7:0] MT_NOCFG   = 8'hFF;

    localparam int FIXED_N = 88;

    typedef enum logic [2:0] {
        SEL_FIXED   = 3'd0,
        SEL_VBASE   = 3'd1,
        SEL_VMASK   = 3'd2,
        SEL_DEFAULT = 3'd3,
        SEL_HILIM   = 3'd4
    } wr_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } state_e;

endpackage

// File: rtl/memtype_cfg.sv
module memtype_cfg
    import memtype_pkg::*;
#(
    parameter int PA_W     = 36,
    parameter int N_VAR    = 8,
    parameter int WR_IDX_W = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_sel,
    input  logic [WR_IDX_W-1:0]             wr_idx,
    input  logic [PA_W-1:0]                 wr_data,
    output logic [FIXED_N-1:0][7:0]         fixed_tbl,
    output logic [N_VAR-1:0][PA_W-1:0]      var_base,
    output logic [N_VAR-1:0][PA_W-1:0]      var_mask,
    output logic [7:0]                      dflt_type,
    output logic [1:0]                      en_field,
    output logic [PA_W-1:0]                 hi_limit,
    output logic                            cfg_done
);

    localparam int GRAIN_BITS = 23;
    localparam logic [PA_W-1:0] HI_KEEP = {{(PA_W-GRAIN_BITS){1'b1}}, {GRAIN_BITS{1'b0}}};

    typedef struct packed {
        logic [FIXED_N-1:0][7:0]    fixed;
        logic [N_VAR-1:0][PA_W-1:0] base;
        logic [N_VAR-1:0][PA_W-1:0] mask;
        logic [7:0]                 dflt;
        logic [1:0]                 en;
        logic [PA_W-1:0]            hilim;
        logic                       done;
    } regs_t;

    regs_t regs_d, regs_q;
    wr_sel_e sel;

    always_comb begin
        sel    = wr_sel_e'(wr_sel);
        regs_d = regs_q;
        if (wr_en) begin
            unique case (sel)
                SEL_FIXED: begin
                    for (int i = 0; i < FIXED_N; i++) begin
                        if (wr_idx == WR_IDX_W'(i)) regs_d.fixed[i] = wr_data[7:0];
                    end
                end
                SEL_VBASE: begin
                    for (int i = 0; i < N_VAR; i++) begin
                        if (wr_idx == WR_IDX_W'(i)) regs_d.base[i] = wr_data;
                    end
                end
                SEL_VMASK: begin
                    for (int i = 0; i < N_VAR; i++) begin
                        if (wr_idx == WR_IDX_W'(i)) regs_d.mask[i] = wr_data;
                    end
                end
                SEL_DEFAULT: begin
                    regs_d.dflt = wr_data[7:0];
                    regs_d.en   = wr_data[11:10];
                    regs_d.done = 1'b1;
                end
                SEL_HILIM: regs_d.hilim = wr_data & HI_KEEP;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign fixed_tbl = regs_q.fixed;
    assign var_base  = regs_q.base;
    assign var_mask  = regs_q.mask;
    assign dflt_type = regs_q.dflt;
    assign en_field  = regs_q.en;
    assign hi_limit  = regs_q.hilim;
    assign cfg_done  = regs_q.done;

endmodule

// File: rtl/memtype_fixed_sel.sv
module memtype_fixed_sel
    import memtype_pkg::*;
(
    input  logic [7:0]              page,      // address bits 19:12
    input  logic [FIXED_N-1:0][7:0] table_q,
    output logic [7:0]              ftype
);

    logic [6:0] slot;

    always_comb begin
        if (!page[7])      slot = {4'd0, page[6:4]};          // 64 KiB granules
        else if (!page[6]) slot = 7'd8  + {3'd0, page[5:2]};  // 16 KiB granules
        else               slot = 7'd24 + {1'b0, page[5:0]};  // 4 KiB granules
        ftype = table_q[slot];
    end

endmodule

// File: rtl/memtype_entry_eval.sv
module memtype_entry_eval
    import memtype_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] mask,
    input  logic [PA_W-1:0] start_addr,
    input  logic [PA_W-1:0] last_addr,
    input  logic [7:0]      prev_type,
    input  logic            prev_ok,
    output logic            stop,
    output logic [7:0]      stop_type,
    output logic [7:0]      next_type,
    output logic            next_ok
);

    localparam logic [PA_W-1:0] PAGE_KEEP = {{(PA_W-12){1'b1}}, 12'h000};

    logic [PA_W-1:0] cmp_mask;
    logic            live, hit_s, hit_e;
    logic [7:0]      cur;

    always_comb begin
        live      = mask[11];
        cmp_mask  = mask & PAGE_KEEP;
        hit_s     = ((start_addr ^ base) & cmp_mask) == '0;
        hit_e     = ((last_addr ^ base) & cmp_mask) == '0;
        cur       = base[7:0];
        stop      = 1'b0;
        stop_type = MT_UC;
        next_type = prev_type;
        next_ok   = prev_ok;
        if (live) begin
            if (hit_s != hit_e) begin
                stop      = 1'b1;
                stop_type = MT_PARTIAL;
            end else if (hit_s) begin
                if (!prev_ok) begin
                    next_type = cur;
                    next_ok   = 1'b1;
                end else if (prev_type == MT_UC || cur == MT_UC) begin
                    stop = 1'b1;
                end else if ((prev_type == MT_WB && cur == MT_WT) ||
                             (prev_type == MT_WT && cur == MT_WB)) begin
                    next_type = MT_WT;
                end else if (prev_type != cur) begin
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
    import memtype_pkg::*;
#(
    parameter int PA_W      = 36,
    parameter int N_VAR     = 8,
    parameter bit HAS_FIXED = 1'b1,
    parameter int WR_IDX_W  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [WR_IDX_W-1:0] wr_idx,
    input  logic [PA_W-1:0]     wr_data,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [PA_W-1:0]     req_start,
    input  logic [PA_W-1:0]     req_end,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [7:0]          rsp_type
);

    localparam int IDX_W = (N_VAR > 1) ? $clog2(N_VAR) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_VAR - 1);

    typedef struct packed {
        state_e          st;
        logic [IDX_W-1:0] idx;
        logic [PA_W-1:0] start;
        logic [PA_W-1:0] last;
        logic [7:0]      prev;
        logic            prev_ok;
        logic [7:0]      result;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [FIXED_N-1:0][7:0]    fixed_tbl;
    logic [N_VAR-1:0][PA_W-1:0] var_base, var_mask;
    logic [7:0]                 dflt_type;
    logic [1:0]                 en_field;
    logic [PA_W-1:0]            hi_limit;
    logic                       cfg_done;

    memtype_cfg #(.PA_W(PA_W), .N_VAR(N_VAR), .WR_IDX_W(WR_IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .fixed_tbl(fixed_tbl), .var_base(var_base),
        .var_mask(var_mask), .dflt_type(dflt_type), .en_field(en_field),
        .hi_limit(hi_limit), .cfg_done(cfg_done)
    );

    logic [7:0] fixed_type;

    generate
        if (HAS_FIXED) begin : g_fixed
            memtype_fixed_sel u_fix (
                .page(req_start[19:12]), .table_q(fixed_tbl), .ftype(fixed_type)
            );
        end else begin : g_nofixed
            assign fixed_type = MT_UC;
        end
    endgenerate

    logic       ev_stop, ev_ok;
    logic [7:0] ev_stop_type, ev_type;

    memtype_entry_eval #(.PA_W(PA_W)) u_eval (
        .base(var_base[ctx_q.idx]), .mask(var_mask[ctx_q.idx]),
        .start_addr(ctx_q.start), .last_addr(ctx_q.last),
        .prev_type(ctx_q.prev), .prev_ok(ctx_q.prev_ok),
        .stop(ev_stop), .stop_type(ev_stop_type),
        .next_type(ev_type), .next_ok(ev_ok)
    );

    logic in_low_mb, above_4g, hi_hit;

    always_comb begin
        in_low_mb = (req_start[PA_W-1:20] == '0);
        above_4g  = (ctx_q.start[PA_W-1:32] != '0);
        hi_hit    = (hi_limit != '0) && above_4g && (ctx_q.last < hi_limit);

        ctx_d     = ctx_q;
        req_ready = (ctx_q.st == ST_IDLE);
        rsp_valid = (ctx_q.st == ST_DONE);
        rsp_type  = ctx_q.result;

        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.start   = req_start;
                    ctx_d.last    = req_end - 1'b1;
                    ctx_d.idx     = '0;
                    ctx_d.prev    = MT_UC;
                    ctx_d.prev_ok = 1'b0;
                    ctx_d.st      = ST_DONE;
                    if (!cfg_done || en_field == 2'b00) ctx_d.result = MT_NOCFG;
                    else if (HAS_FIXED && in_low_mb)    ctx_d.result = fixed_type;
                    else if (!en_field[1])              ctx_d.result = dflt_type;
                    else                                ctx_d.st     = ST_SCAN;
                end
            end
            ST_SCAN: begin
                ctx_d.prev    = ev_type;
                ctx_d.prev_ok = ev_ok;
                if (ev_stop) begin
                    ctx_d.result = ev_stop_type;
                    ctx_d.st     = ST_DONE;
                end else if (ctx_q.idx == LAST_IDX) begin
                    ctx_d.st = ST_DONE;
                    if (hi_hit)     ctx_d.result = MT_WB;
                    else if (ev_ok) ctx_d.result = ev_type;
                    else            ctx_d.result = dflt_type;
                end else begin
                    ctx_d.idx = ctx_q.idx + 1'b1;
                end
            end
            ST_DONE: begin
                if (rsp_ready) ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '{st: ST_IDLE, default: '0};
        else        ctx_q <= ctx_d;
    end

endmodule

// File: rtl/memtype_resolver_chk.sv
module memtype_resolver_chk #(
    parameter int N_VAR = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [7:0] rsp_type
);

    localparam int CW = $clog2(N_VAR + 2);

    logic          busy;
    logic [CW-1:0] busy_cnt;

    assign busy = !req_ready && !rsp_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !rsp_valid));

    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_type)));

    p_no_accept_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_accept_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));

    p_walk_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CW'(N_VAR)));

endmodule

bind memtype_resolver memtype_resolver_chk #(.N_VAR(N_VAR)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type)
);

// File: tb/memtype_resolver_test.sv
module memtype_resolver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [6:0]  wr_idx = '0;
    logic [35:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [35:0] req_start = '0;
    logic [35:0] req_end = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [7:0]  rsp_type;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    memtype_resolver uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_end(req_end), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_type(rsp_type)
    );

    always #10 clk = ~clk;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input int idx, input logic [35:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = 7'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input string rq, input logic [35:0] s, input logic [35:0] e,
                          input logic [7:0] exp);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_start = s; req_end = e;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({rq, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk(rq, 64'(rsp_type), 64'(exp));
        @(negedge clk);
        chk("R10 hold valid", 64'(rsp_valid), 64'd1);
        chk("R10 hold type", 64'(rsp_type), 64'(exp));
        chk("R10 busy ready", 64'(req_ready), 64'd0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R10 released", 64'({req_ready, rsp_valid}), 64'b10);
    endtask

    task automatic t_reset;
        chk("R1 ready", 64'(req_ready), 64'd1);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_unconfigured;
        lookup("R2 not set up", 36'h0_4000_0000, 36'h0_4000_1000, 8'hFF);
        wr(3'd3, 0, 36'h006);
        lookup("R2 enable zero", 36'h0_4000_0000, 36'h0_4000_1000, 8'hFF);
    endtask

    task automatic t_fixed;
        for (int i = 0; i < 88; i++) wr(3'd0, i, 36'(i));
        wr(3'd3, 0, 36'hC06);
        lookup("R3 first 64K", 36'h0_0000, 36'h0_1000, 8'd0);
        lookup("R3 mid 64K", 36'h3_C000, 36'h3_D000, 8'd3);
        lookup("R3 last 64K", 36'h7_FFFF, 36'h8_0000, 8'd7);
        lookup("R3 first 16K", 36'h8_0000, 36'h8_1000, 8'd8);
        lookup("R3 last 16K", 36'hB_FFFF, 36'hC_0000, 8'd23);
        lookup("R3 first 4K", 36'hC_0000, 36'hC_1000, 8'd24);
        lookup("R3 last 4K end far", 36'hF_F000, 36'h20_0000, 8'd87);
    endtask

    task automatic t_var_basic;
        // entry 0: 256 MiB at 1 GiB, write-combining, junk in ignored low bits
        wr(3'd1, 0, 36'h0_4000_0F01);
        wr(3'd2, 0, 36'hF_F000_0FFF);
        // entry 1: covers same region as uncachable but not valid
        wr(3'd1, 1, 36'h0_4000_0000);
        wr(3'd2, 1, 36'hF_F000_0000);
        lookup("R5 match ignoring low bits and invalid entry", 36'h0_4000_0000, 36'h0_4000_1000, 8'h01);
        lookup("R6 end beyond entry", 36'h0_4FFF_F000, 36'h0_5000_1000, 8'hFE);
        lookup("R6 start before entry", 36'h0_3FFF_F000, 36'h0_4000_1000, 8'hFE);
        lookup("R11 exclusive end", 36'h0_4FFF_F000, 36'h0_5000_0000, 8'h01);
        lookup("R9 no match gives default", 36'h0_2000_0000, 36'h0_2000_1000, 8'h06);
    endtask

    task automatic t_var_disabled;
        wr(3'd3, 0, 36'h404);
        lookup("R4 variable disabled", 36'h0_4000_0000, 36'h0_4000_1000, 8'h04);
        lookup("R3 fixed with variable disabled", 36'h0_0000, 36'h0_1000, 8'd0);
        wr(3'd3, 0, 36'hC06);
    endtask

    task automatic t_merge;
        wr(3'd1, 2, 36'h0_8000_0006);
        wr(3'd2, 2, 36'hF_FF00_0800);
        wr(3'd1, 3, 36'h0_8000_0004);
        wr(3'd2, 3, 36'hF_FF00_0800);
        lookup("R7 WB with WT", 36'h0_8000_0000, 36'h0_8000_1000, 8'h04);
        wr(3'd1, 3, 36'h0_8000_0005);
        lookup("R7 WB with WP", 36'h0_8000_0000, 36'h0_8000_1000, 8'h00);
        wr(3'd1, 3, 36'h0_8000_0006);
        lookup("R7 equal WB", 36'h0_8000_0000, 36'h0_8000_1000, 8'h06);
        wr(3'd1, 3, 36'h0_8000_0000);
        lookup("R7 UC wins", 36'h0_8000_0000, 36'h0_8000_1000, 8'h00);
        wr(3'd1, 7, 36'h0_9000_0005);
        wr(3'd2, 7, 36'hF_FF00_0800);
        lookup("R5 last entry", 36'h0_9000_0000, 36'h0_9000_1000, 8'h05);
    endtask

    task automatic t_override;
        wr(3'd3, 0, 36'hC00);
        wr(3'd1, 4, 36'h1_0000_0001);
        wr(3'd2, 4, 36'hF_FF00_0800);
        wr(3'd4, 0, 36'h2_007F_FFFF);
        lookup("R8 override beats entry", 36'h1_0000_0000, 36'h1_0000_1000, 8'h06);
        lookup("R8 end just inside", 36'h1_8000_0000, 36'h2_0000_0000, 8'h06);
        lookup("R8 limit masked", 36'h1_8000_0000, 36'h2_0000_0001, 8'h00);
        lookup("R8 below 4G", 36'h0_2000_0000, 36'h0_2000_1000, 8'h00);
        wr(3'd4, 0, 36'h0_007F_FFFF);
        lookup("R8 limit cleared by mask", 36'h1_8000_0000, 36'h1_8000_1000, 8'h00);
        lookup("R8 entry visible without limit", 36'h1_0000_0000, 36'h1_0000_1000, 8'h01);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL R10: watchdog expired, actual hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unconfigured();
        t_fixed();
        t_var_basic();
        t_var_disabled();
        t_merge();
        t_override();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule